// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for each beat of a four-beat memory burst. A load strobe starts a burst and captures the external address. After that, each advance strobe steps the two low address bits to the next position in the burst. The upper bits stay as they were captured. The same sequencing serves read bursts and write bursts. The logic that decides which cycle starts a burst lives outside this block and drives the strobes.

There are two step orders. In the interleaved order, beat k is the start value XOR k. In the linear order, beat k is the start value plus k, modulo four. The order is chosen by a mode pin, which is captured while reset is asserted and then held.

Top module: `burst_seq`

## Requirements
- R1: While reset is low and after it is released, with no load yet, `addr_out` is all zeros.
- R2: When `load` is high at a rising edge, `addr_out` equals the `addr_in` value sampled at that edge from the following cycle on, and that value counts as beat 0.
- R3: With `mode_ilv` high during reset, beat k of a burst has low bits equal to start[1:0] XOR k (for example, start 01 gives 01, 00, 11, 10).
- R4: With `mode_ilv` low during reset, beat k has low bits equal to (start[1:0] + k) mod 4 (for example, start 11 gives 11, 00, 01, 10).
- R5: The burst moves to its next beat only when `adv_n` is sampled low at a rising edge. While `adv_n` is high, `addr_out` holds its value.
- R6: When `load` and an advance occur at the same edge, the load wins: `addr_out` becomes the new `addr_in` at beat 0.
- R7: Bits [ADDR_W-1:2] of `addr_out` keep the captured start value for the whole burst. The low bits never leave the aligned group of four words.
- R8: A fourth advance after the start returns `addr_out` to the start address, and further advances repeat the same order.
- R9: The order is set only by `mode_ilv` sampled during reset. Changing `mode_ilv` after reset has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; also the window in which the mode is captured |
| mode_ilv | input | 1 | Order select: 1 = interleaved (XOR), 0 = linear (modulo-4 add) |
| load | input | 1 | Burst start: capture `addr_in` as beat 0 |
| adv_n | input | 1 | Active-low advance to the next beat |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current burst word address |

## Verification
The bench runs full bursts from every start value in both orders and lets them wrap past the fourth beat. A design with the orders swapped, with a carry leaking into the upper bits, or with a broken wrap shows a wrong address on a specific beat. It holds `adv_n` high in the middle of a burst, so a design that advances unconditionally drifts. It asserts load and advance together, so a design that gives the advance priority lands on beat 1 instead of beat 0. It toggles `mode_ilv` after reset, so a design that follows the live pin switches order in the middle of a burst.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ilv,
  input  logic              load,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);

  localparam int LOW_W = 2;

  logic              mode_q;
  logic [ADDR_W-1:0] base_q;
  logic [LOW_W-1:0]  beat_q;
  logic [LOW_W-1:0]  low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= mode_ilv;
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= addr_in;
      beat_q <= '0;
    end else if (!adv_n) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign low      = mode_q ? (base_q[LOW_W-1:0] ^ beat_q) : (base_q[LOW_W-1:0] + beat_q);
  assign addr_out = {base_q[ADDR_W-1:LOW_W], low};

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr_out == $past(addr_in));

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv_n) |=> $stable(addr_out));

  assert_upper_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> addr_out[ADDR_W-1:LOW_W] == $past(addr_out[ADDR_W-1:LOW_W]));

  assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !load && !adv_n) |=> addr_out[LOW_W-1:0] == LOW_W'($past(addr_out[LOW_W-1:0]) + 1'b1));

  assert_ilv_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !load && !adv_n) |=>
      (addr_out[LOW_W-1:0] ^ base_q[LOW_W-1:0]) ==
      LOW_W'(($past(addr_out[LOW_W-1:0]) ^ $past(base_q[LOW_W-1:0])) + 1'b1));

  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_ilv) |=> $stable(mode_q));

endmodule

// File: tb/burst_seq_tb.sv
`timescale 1ns/1ps
module burst_seq_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_ilv = 1'b1;
  logic          load = 1'b0;
  logic          adv_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  burst_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_ilv(mode_ilv), .load(load),
    .adv_n(adv_n), .addr_in(addr_in), .addr_out(addr_out)
  );

  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] s, int k, bit ilv);
    logic [1:0] lo;
    lo = ilv ? (s[1:0] ^ 2'(k)) : 2'(s[1:0] + 2'(k));
    return {s[AW-1:2], lo};
  endfunction

  task automatic chk(string req, logic [AW-1:0] exp);
    n_chk++;
    if (addr_out !== exp) begin
      n_bad++;
      $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset(bit m);
    rst_n = 1'b0; mode_ilv = m; load = 1'b0; adv_n = 1'b1;
    tick(); tick();
    chk("R1 in reset", '0);
    rst_n = 1'b1;
    tick();
    chk("R1 after reset", '0);
  endtask

  task automatic t_burst(logic [AW-1:0] s, bit ilv, int extra);
    load = 1'b1; adv_n = 1'b1; addr_in = s;
    tick();
    load = 1'b0; addr_in = ~s;
    chk("R2 start", s);
    adv_n = 1'b0;
    for (int k = 1; k <= 4 + extra; k++) begin
      tick();
      if (k % 4 == 0) chk("R8 wrap", s);
      else chk(ilv ? "R3 R7 ilv beat" : "R4 R7 lin beat", beat_addr(s, k, ilv));
    end
    adv_n = 1'b1;
  endtask

  task automatic t_hold(logic [AW-1:0] s, bit ilv);
    load = 1'b1; addr_in = s;
    tick();
    load = 1'b0; adv_n = 1'b0;
    tick();
    adv_n = 1'b1;
    tick(); tick(); tick();
    chk("R5 hold", beat_addr(s, 1, ilv));
    adv_n = 1'b0;
    tick();
    adv_n = 1'b1;
    chk("R5 resume", beat_addr(s, 2, ilv));
  endtask

  task automatic t_priority(logic [AW-1:0] a, logic [AW-1:0] b);
    load = 1'b1; addr_in = a; adv_n = 1'b0;
    tick();
    chk("R6 first", a);
    load = 1'b1; addr_in = b; adv_n = 1'b0;
    tick();
    load = 1'b0; adv_n = 1'b1;
    chk("R6 load beats advance", b);
  endtask

  task automatic t_mode_frozen(logic [AW-1:0] s, bit ilv_at_reset);
    load = 1'b1; addr_in = s;
    tick();
    load = 1'b0;
    mode_ilv = ~ilv_at_reset;
    adv_n = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      tick();
      chk("R9 mode ignored", beat_addr(s, k, ilv_at_reset));
    end
    adv_n = 1'b1;
    mode_ilv = ilv_at_reset;
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: addr_out=%h expected=done", addr_out);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset(1'b1);
    for (int s = 0; s < 4; s++) t_burst(16'hA5C0 | 16'(s), 1'b1, 1);
    t_burst(16'hFFFE, 1'b1, 4);
    t_hold(16'h1231, 1'b1);
    t_priority(16'h4442, 16'h7773);
    t_mode_frozen(16'h0E01, 1'b1);
    t_reset(1'b0);
    for (int s = 0; s < 4; s++) t_burst(16'h3BF4 | 16'(s), 1'b0, 1);
    t_burst(16'hFFFF, 1'b0, 0);
    t_hold(16'h8002, 1'b0);
    t_priority(16'h0101, 16'hFEFE);
    t_mode_frozen(16'h0E01, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule